// File: doc/BRIEF.md
# Host Port Slave with Split-Halfword Transfers

The block lets an external host move 32-bit words into and out of an internal memory space through a 16-bit port. The host addresses three registers with a 2-bit select: a control register, an address register and a data register. The data register can be reached in two modes. In one mode the address advances after every completed word. In the other mode the address stays fixed. Every 32-bit word crosses the port as two halfword cycles, and a dedicated line tells the block which half is being moved.

A host cycle starts when chip select is low and exactly one of the two data strobes is low. Internally the block issues one request/acknowledge memory access per word. A data write reaches memory only once both halves are in. A data read fetches the whole word on the first half and serves the second half from a buffer. A ready output holds the host off while a memory access is in flight. The control register gives the host a bit that pulses an interrupt to the core and a bit that drives the host interrupt pin. The core can also set that second bit.

Top module: `host_port_slave`

## Requirements
- R1: A host access is accepted once, on the clock where `hp_cs_n` is low and exactly one of `hp_stb_a_n`, `hp_stb_b_n` is low after not being so. With both strobes low, both strobes high, or `hp_cs_n` high, no register changes.
- R2: `hp_regsel` encodes 00 = control, 01 = address, 10 = data with auto-increment, 11 = data with fixed address. `hp_rnw` = 1 is a read. `hp_upper` = 0 moves bits 15:0 and `hp_upper` = 1 moves bits 31:16.
- R3: An address write with `hp_upper` = 0 loads byte-address bits 15:2, and bits 1:0 always read 0. With `hp_upper` = 1 it loads bits ADDR_W-1:16. Address reads return the value zero-extended to 32 bits.
- R4: A data write buffers the lower halfword and issues no memory request. The upper halfword then issues one write of {upper, lower} at `mem_addr` = byte address / 4.
- R5: A data read with `hp_upper` = 0 issues one memory read and returns bits 15:0. A following read with `hp_upper` = 1 returns bits 31:16 of the same word and issues no memory request.
- R6: In select 10 the address rises by 4 after each completed word: on the write acknowledge, or on the upper-half read. In select 11 it never changes.
- R7: `hp_rdy_n` is high whenever `hp_cs_n` is high or a memory request is outstanding. It is low when the host is selected and the block is idle.
- R8: Writing 1 to control bit 0 (lower halfword) gives a `core_irq` pulse exactly one cycle long. Control bit 0 always reads 0.
- R9: Control bit 1 drives `hp_int_n` low while it is 1, and host writes set or clear it. `core_hint_set` sets it, and it overrides a host write that falls on the same clock.
- R10: Control writes with `hp_upper` = 1 have no effect, and control reads with `hp_upper` = 1 return 0.
- R11: After reset `hp_int_n` = 1, `core_irq` = 0, `mem_req` = 0, `hp_dout` = 0, and the address register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_cs_n | input | 1 | Host chip select, active low |
| hp_stb_a_n | input | 1 | Host data strobe A, active low |
| hp_stb_b_n | input | 1 | Host data strobe B, active low |
| hp_rnw | input | 1 | 1 = host read, 0 = host write |
| hp_regsel | input | 2 | Register select |
| hp_upper | input | 1 | Halfword select, 1 = bits 31:16 |
| hp_din | input | 16 | Host write data |
| hp_dout | output | 16 | Host read data |
| hp_dout_en | output | 1 | Output enable for the host data bus |
| hp_rdy_n | output | 1 | Ready to the host, active low |
| hp_int_n | output | 1 | Interrupt to the host, active low |
| core_hint_set | input | 1 | Core request to set the host interrupt bit |
| core_irq | output | 1 | One-cycle interrupt to the core |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |

## Verification
Two writers can reach the host interrupt bit on the same clock: a host control write and the core's set request. The bench places the core request on exactly the clock that accepts a host write clearing that bit. It then judges at `hp_int_n` that the core request won. A later host write with no core request must still clear the bit.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL     = 2'b00,
    SEL_ADDR     = 2'b01,
    SEL_DATA_INC = 2'b10,
    SEL_DATA_FIX = 2'b11
  } hsel_e;

  typedef struct packed {
    hsel_e       sel;
    logic        rd;
    logic        upper;
    logic [15:0] wdata;
  } hacc_t;

  localparam int CTRL_IRQ_BIT  = 0;
  localparam int CTRL_HINT_BIT = 1;
  localparam int CTRL_W        = 2;

endpackage

// File: rtl/hps_strobe.sv
module hps_strobe (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic stb_a_n,
  input  logic stb_b_n,
  output logic active,
  output logic start
);
  logic act_q;

  // a cycle is live only with the chip selected and a single strobe low
  assign active = ~cs_n & (stb_a_n ^ stb_b_n);
  assign start  = active & ~act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= active;
  end

  // R1: one acceptance per strobe, never on two clocks in a row
  p_single_start_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

endmodule

// File: rtl/hps_ctrl.sv
module hps_ctrl
  import hps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_bits,
  input  logic              core_hint_set,
  output logic              core_irq,
  output logic              hint,
  output logic [15:0]       rdata
);
  logic irq_q, hint_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      hint_q <= 1'b0;
    end else begin
      irq_q <= wr_en & wr_bits[CTRL_IRQ_BIT];
      if (core_hint_set)  hint_q <= 1'b1;
      else if (wr_en)     hint_q <= wr_bits[CTRL_HINT_BIT];
    end
  end

  always_comb begin
    rdata                = '0;
    rdata[CTRL_HINT_BIT] = hint_q;
  end

  assign core_irq = irq_q;
  assign hint     = hint_q;

  // R8: the core interrupt never lasts two cycles
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    core_irq |=> !core_irq);
  // R9: a core set request always leaves the bit set
  p_core_wins_r9: assert property (@(posedge clk) disable iff (rst)
    core_hint_set |=> hint);

endmodule

// File: rtl/hps_xfer.sv
module hps_xfer
  import hps_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  hacc_t             acc,
  input  logic [15:0]       ctrl_rdata,
  output logic              busy,
  output logic [15:0]       dout,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  localparam int HI_W = ADDR_W - 16;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       lo_buf_q, dout_q;
  logic [31:0]       rd_buf_q, wdata_q;
  logic              pend_q, pend_we_q, pend_inc_q;
  logic [31:0]       addr_ext;
  logic              inc_mode;

  assign addr_ext = 32'(addr_q);
  assign inc_mode = (acc.sel == SEL_DATA_INC);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      lo_buf_q   <= '0;
      dout_q     <= '0;
      rd_buf_q   <= '0;
      wdata_q    <= '0;
      pend_q     <= 1'b0;
      pend_we_q  <= 1'b0;
      pend_inc_q <= 1'b0;
    end else begin
      if (go) begin
        case (acc.sel)
          SEL_CTRL: begin
            if (acc.rd) dout_q <= acc.upper ? 16'h0000 : ctrl_rdata;
          end
          SEL_ADDR: begin
            if (acc.rd)         dout_q <= acc.upper ? addr_ext[31:16] : addr_ext[15:0];
            else if (acc.upper) addr_q[ADDR_W-1:16] <= acc.wdata[HI_W-1:0];
            else                addr_q[15:0] <= {acc.wdata[15:2], 2'b00};
          end
          default: begin
            if (acc.rd) begin
              if (!acc.upper) begin
                pend_q     <= 1'b1;
                pend_we_q  <= 1'b0;
                pend_inc_q <= 1'b0;
              end else begin
                dout_q <= rd_buf_q[31:16];
                if (inc_mode) addr_q <= addr_q + STEP;
              end
            end else begin
              if (!acc.upper) begin
                lo_buf_q <= acc.wdata;
              end else begin
                pend_q     <= 1'b1;
                pend_we_q  <= 1'b1;
                pend_inc_q <= inc_mode;
                wdata_q    <= {acc.wdata, lo_buf_q};
              end
            end
          end
        endcase
      end
      if (pend_q && mem_ack) begin
        pend_q <= 1'b0;
        if (!pend_we_q) begin
          rd_buf_q <= mem_rdata;
          dout_q   <= mem_rdata[15:0];
        end
        if (pend_inc_q) addr_q <= addr_q + STEP;
      end
    end
  end

  assign busy      = pend_q;
  assign dout      = dout_q;
  assign mem_req   = pend_q;
  assign mem_we    = pend_we_q;
  assign mem_addr  = addr_q[ADDR_W-1:2];
  assign mem_wdata = wdata_q;

  // R4: an outstanding request keeps its address, data and direction
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    pend_q && !mem_ack |=> pend_q && $stable(addr_q) && $stable(wdata_q) && $stable(pend_we_q));
  // R7: the acknowledge retires the request on the next clock
  p_ack_drop_r7: assert property (@(posedge clk) disable iff (rst)
    pend_q && mem_ack |=> !pend_q);
  // R5: returned read data lands on the host bus low half
  p_read_lo_r5: assert property (@(posedge clk) disable iff (rst)
    pend_q && mem_ack && !pend_we_q |=> dout_q == $past(mem_rdata[15:0]));

endmodule

// File: rtl/host_port_slave.sv
module host_port_slave
  import hps_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hp_cs_n,
  input  logic              hp_stb_a_n,
  input  logic              hp_stb_b_n,
  input  logic              hp_rnw,
  input  logic [1:0]        hp_regsel,
  input  logic              hp_upper,
  input  logic [15:0]       hp_din,
  output logic [15:0]       hp_dout,
  output logic              hp_dout_en,
  output logic              hp_rdy_n,
  output logic              hp_int_n,
  input  logic              core_hint_set,
  output logic              core_irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  logic        act, start, busy, go, ctrl_wr, hint, oe_q;
  logic [15:0] ctrl_rdata;
  hacc_t       acc;

  assign acc     = '{sel: hsel_e'(hp_regsel), rd: hp_rnw, upper: hp_upper, wdata: hp_din};
  assign go      = start & ~busy;
  assign ctrl_wr = go & (acc.sel == SEL_CTRL) & ~acc.rd & ~acc.upper;

  hps_strobe u_strobe (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (hp_cs_n),
    .stb_a_n (hp_stb_a_n),
    .stb_b_n (hp_stb_b_n),
    .active  (act),
    .start   (start)
  );

  hps_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (ctrl_wr),
    .wr_bits       (hp_din[CTRL_W-1:0]),
    .core_hint_set (core_hint_set),
    .core_irq      (core_irq),
    .hint          (hint),
    .rdata         (ctrl_rdata)
  );

  hps_xfer #(.ADDR_W(ADDR_W)) u_xfer (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .acc        (acc),
    .ctrl_rdata (ctrl_rdata),
    .busy       (busy),
    .dout       (hp_dout),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= act & hp_rnw;
  end

  assign hp_dout_en = oe_q;
  assign hp_rdy_n   = hp_cs_n | busy | start;
  assign hp_int_n   = ~hint;

  // R9: the pin follows a core set request on the next clock
  p_pin_follows_core_r9: assert property (@(posedge clk) disable iff (rst)
    core_hint_set |=> !hp_int_n);
  // R7: deselecting the port withdraws ready
  p_desel_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(hp_cs_n) |-> hp_rdy_n);

endmodule

// File: tb/host_port_slave_test.sv
module host_port_slave_test;
  localparam int ADDR_W = 20;
  localparam int WA_W   = ADDR_W - 2;
  localparam int LAT    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hp_cs_n = 1'b1, hp_stb_a_n = 1'b1, hp_stb_b_n = 1'b1, hp_rnw = 1'b0;
  logic [1:0]  hp_regsel = 2'b00;
  logic hp_upper = 1'b0;
  logic [15:0] hp_din = '0;
  logic [15:0] hp_dout;
  logic hp_dout_en, hp_rdy_n, hp_int_n, core_irq, mem_req, mem_we;
  logic core_hint_set = 1'b0;
  logic [WA_W-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int irq_cnt = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int lat_cnt = 0;

  typedef struct packed { logic [WA_W-1:0] a; logic [31:0] d; } wexp_t;
  wexp_t wq[$];
  logic [31:0] mem [0:255];

  always #5 clk = ~clk;

  host_port_slave #(.ADDR_W(ADDR_W)) uut (.*);

  function automatic logic [31:0] pat(int i);
    return 32'hC0DE0000 + 32'(i) * 32'h00010003;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model and write monitor (scoreboard consumer)
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      lat_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (lat_cnt == LAT) begin
        lat_cnt = 0;
        mem_ack = 1'b1;
        if (mem_we) begin
          wr_cnt++;
          mem[mem_addr[7:0]] = mem_wdata;
          if (wq.size() == 0) begin
            checks++; errors++;
            $display("FAIL R4 unexpected write actual %h expected none", mem_wdata);
          end else begin
            wexp_t e;
            e = wq.pop_front();
            check("R4 write address", 32'(mem_addr), 32'(e.a));
            check("R4 write data", mem_wdata, e.d);
          end
        end else begin
          rd_cnt++;
          mem_rdata = mem[mem_addr[7:0]];
        end
      end else begin
        lat_cnt++;
      end
    end
    if (!rst && core_irq) irq_cnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 60000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic hacc(input logic rd, input logic [1:0] sel, input logic up,
                      input logic [15:0] wd, input logic use_b,
                      output logic [15:0] rv, output logic saw_busy);
    int n;
    @(negedge clk);
    hp_cs_n = 1'b0; hp_rnw = rd; hp_regsel = sel; hp_upper = up; hp_din = wd;
    if (use_b) hp_stb_b_n = 1'b0; else hp_stb_a_n = 1'b0;
    saw_busy = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      if (hp_rdy_n) saw_busy = 1'b1;
      n++;
    end while (hp_rdy_n && n < 200);
    rv = hp_dout;
    hp_stb_a_n = 1'b1; hp_stb_b_n = 1'b1; hp_cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic hwr(input logic [1:0] sel, input logic up, input logic [15:0] wd);
    logic [15:0] rv; logic b;
    hacc(1'b0, sel, up, wd, 1'b0, rv, b);
  endtask

  task automatic hrd(input logic [1:0] sel, input logic up, output logic [15:0] rv);
    logic b;
    hacc(1'b1, sel, up, 16'h0, 1'b0, rv, b);
  endtask

  task automatic set_addr(input logic [31:0] a);
    hwr(2'b01, 1'b0, a[15:0]);
    hwr(2'b01, 1'b1, a[31:16]);
  endtask

  initial begin
    logic [15:0] v;
    logic b;
    int irq0, rd0, wr0;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check("R11 hp_int_n", 32'(hp_int_n), 32'd1);
    check("R11 core_irq", 32'(core_irq), 32'd0);
    check("R11 mem_req", 32'(mem_req), 32'd0);
    check("R11 hp_dout", 32'(hp_dout), 32'd0);
    check("R7 not selected", 32'(hp_rdy_n), 32'd1);
    hrd(2'b01, 1'b0, v);
    check("R11 address low", 32'(v), 32'd0);

    // R7 idle and selected
    hp_cs_n = 1'b0;
    @(negedge clk);
    check("R7 selected idle", 32'(hp_rdy_n), 32'd0);
    hp_cs_n = 1'b1;

    // R3 address register
    hwr(2'b01, 1'b0, 16'h1237);
    hrd(2'b01, 1'b0, v);
    check("R3 low half", 32'(v), 32'h1234);
    hwr(2'b01, 1'b1, 16'hFFFF);
    hrd(2'b01, 1'b1, v);
    check("R3 high half", 32'(v), 32'h000F);
    hrd(2'b01, 1'b0, v);
    check("R2 halves independent", 32'(v), 32'h1234);

    // R4 and R6: increment-mode writes at 0x40
    set_addr(32'h40);
    wr0 = wr_cnt;
    hwr(2'b10, 1'b0, 16'hBEEF);
    check("R4 no request after lower", 32'(mem_req), 32'd0);
    check("R4 no write after lower", 32'(wr_cnt), 32'(wr0));
    wq.push_back('{a: WA_W'(32'h10), d: 32'hDEADBEEF});
    hwr(2'b10, 1'b1, 16'hDEAD);
    wq.push_back('{a: WA_W'(32'h11), d: 32'h5678_1234});
    hwr(2'b10, 1'b0, 16'h1234);
    hwr(2'b10, 1'b1, 16'h5678);
    hrd(2'b01, 1'b0, v);
    check("R6 address after two writes", 32'(v), 32'h48);
    check("R4 write count", 32'(wr_cnt), 32'(wr0 + 2));
    check("R4 all writes seen", 32'(wq.size()), 32'd0);

    // R5 and R6: fixed-mode reads
    set_addr(32'h40);
    rd0 = rd_cnt;
    hacc(1'b1, 2'b11, 1'b0, 16'h0, 1'b0, v, b);
    check("R5 lower half", 32'(v), 32'hBEEF);
    check("R7 busy during fetch", 32'(b), 32'd1);
    hrd(2'b11, 1'b1, v);
    check("R5 upper half", 32'(v), 32'hDEAD);
    check("R5 single fetch", 32'(rd_cnt), 32'(rd0 + 1));
    hrd(2'b11, 1'b0, v);
    check("R6 fixed mode repeat", 32'(v), 32'hBEEF);
    hrd(2'b01, 1'b0, v);
    check("R6 fixed address kept", 32'(v), 32'h40);

    // R6 increment-mode reads across two words
    hrd(2'b10, 1'b0, v);
    hrd(2'b10, 1'b1, v);
    check("R5 inc upper", 32'(v), 32'hDEAD);
    hrd(2'b10, 1'b0, v);
    check("R6 next word lower", 32'(v), 32'h1234);
    hrd(2'b10, 1'b1, v);
    check("R6 next word upper", 32'(v), 32'h5678);
    hrd(2'b01, 1'b0, v);
    check("R6 address after reads", 32'(v), 32'h48);
    set_addr(32'h80);
    hrd(2'b11, 1'b0, v);
    check("R5 untouched word lower", 32'(v), 32'(pat(32'h20) & 32'hFFFF));
    hrd(2'b11, 1'b1, v);
    check("R5 untouched word upper", 32'(v), 32'(pat(32'h20) >> 16));

    // R8 core interrupt pulse
    irq0 = irq_cnt;
    hacc(1'b0, 2'b00, 1'b0, 16'h0001, 1'b0, v, b);
    check("R7 control access not delayed", 32'(b), 32'd0);
    check("R8 one pulse", 32'(irq_cnt), 32'(irq0 + 1));
    hrd(2'b00, 1'b0, v);
    check("R8 bit0 reads zero", 32'(v), 32'h0);

    // R9 host interrupt bit
    hwr(2'b00, 1'b0, 16'h0002);
    check("R9 pin low", 32'(hp_int_n), 32'd0);
    hrd(2'b00, 1'b0, v);
    check("R9 readback", 32'(v), 32'h0002);
    hwr(2'b00, 1'b0, 16'h0000);
    check("R9 cleared by host", 32'(hp_int_n), 32'd1);

    // R10 control upper half ignored
    irq0 = irq_cnt;
    hwr(2'b00, 1'b1, 16'h0003);
    check("R10 no pulse", 32'(irq_cnt), 32'(irq0));
    check("R10 pin unchanged", 32'(hp_int_n), 32'd1);
    hrd(2'b00, 1'b1, v);
    check("R10 upper reads zero", 32'(v), 32'h0);

    // R1 strobe qualification
    irq0 = irq_cnt;
    @(negedge clk);
    hp_cs_n = 1'b0; hp_rnw = 1'b0; hp_regsel = 2'b00; hp_upper = 1'b0; hp_din = 16'h0003;
    hp_stb_a_n = 1'b0; hp_stb_b_n = 1'b0;
    repeat (3) @(negedge clk);
    hp_stb_a_n = 1'b1; hp_stb_b_n = 1'b1; hp_cs_n = 1'b1;
    @(negedge clk);
    hp_stb_a_n = 1'b0;
    repeat (3) @(negedge clk);
    hp_stb_a_n = 1'b1;
    @(negedge clk);
    check("R1 both strobes ignored pin", 32'(hp_int_n), 32'd1);
    check("R1 both strobes ignored irq", 32'(irq_cnt), 32'(irq0));
    hacc(1'b0, 2'b00, 1'b0, 16'h0002, 1'b1, v, b);
    check("R1 strobe b accepted", 32'(hp_int_n), 32'd0);
    hwr(2'b00, 1'b0, 16'h0000);

    // R9 same-clock collision: core set against host clear
    @(negedge clk);
    hp_cs_n = 1'b0; hp_rnw = 1'b0; hp_regsel = 2'b00; hp_upper = 1'b0; hp_din = 16'h0000;
    hp_stb_a_n = 1'b0; core_hint_set = 1'b1;
    @(negedge clk);
    core_hint_set = 1'b0;
    hp_stb_a_n = 1'b1; hp_cs_n = 1'b1;
    @(negedge clk);
    check("R9 core set wins", 32'(hp_int_n), 32'd0);
    hwr(2'b00, 1'b0, 16'h0000);
    check("R9 later host clear", 32'(hp_int_n), 32'd1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule